// File: doc/BRIEF.md
# Single-Precision Reciprocal Unit

This block returns 1/x for a 32-bit IEEE-754 binary32 operand. A request is offered on a valid/ready input. The unit takes one operand at a time. While it works on that operand, `in_ready` stays low, and any `in_valid` seen during that time is back-pressured and has no effect. When the result is ready, `out_data` is updated and `out_done` pulses for one cycle. The output has no back-pressure. `out_data` holds its value until the next result is written.

The result exponent is formed by reflecting the biased input exponent about the bias. The significand reciprocal works in fixed point. A seed comes from a computed table that is indexed by the leading fraction bits. The seed is then refined by Newton-Raphson steps. Each step has two phases. The first forms the residual e = 1 - m*x. The second forms the correction x + x*e. Both phases time-share one signed multiplier. The number of steps is a parameter, and its default is 2. Round-to-nearest (ties up) is applied once, when the result is packed.

Top module: `recip_nr_unit`

## Requirements
- R1: `in_ready` is high exactly while the unit is idle. An operand is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_valid` asserted while `in_ready` is low is ignored and does not change the pending result.
- R2: `out_done` is high for exactly one cycle. It rises 2*NR_STEPS+1 rising edges after the accepting edge, which is 5 with the defaults. `out_data` changes only on the edge that raises `out_done`.
- R3: For a normal input whose result is not flushed and whose fraction field is nonzero, the result is normal and keeps the input sign. Its value is within 1 ulp of the exact reciprocal.
- R4: A normal input with fraction field 0 and biased exponent e in 1..253 returns exactly sign, biased exponent 254-e, and fraction 0.
- R5: An input with exponent field 0 (zero or denormal, since denormals are flushed) returns infinity with the input sign: exponent 0xFF, fraction 0.
- R6: An infinite input (exponent 0xFF, fraction 0) returns zero with the input sign.
- R7: A NaN input (exponent 0xFF, fraction nonzero) returns the quiet NaN 0x7FC00000.
- R8: A normal input with biased exponent 254, or with biased exponent 253 and a nonzero fraction, returns zero with the input sign, because its reciprocal falls below the normal range.
- R9: After reset, `in_ready` is 1, `out_done` is 0 and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand will be taken |
| in_data | input | 32 | binary32 operand |
| out_done | output | 1 | One-cycle result strobe |
| out_data | output | 32 | binary32 reciprocal, held between strobes |

## Verification
With the defaults, every result is due on the fifth rising edge after the accepting edge. This applies to special values too, since they pass through the same state sequence. The bench drives inputs and samples outputs only on falling edges. After each accept it requires `out_done` low and `in_ready` low on the five falling edges that follow. It then requires `out_done` high on the sixth falling edge, compares `out_data` there, and requires `out_done` low again one falling edge later. On some requests the bench keeps `in_valid` high with different data throughout the busy window, to show that the pending result is unaffected.

// File: rtl/recip_pkg.sv
package recip_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_RES, ST_COR, ST_PACK} recip_state_t;

  typedef enum logic [1:0] {CL_NORM, CL_ZERO, CL_INF, CL_NAN} op_class_t;

  // Rounded reciprocal of the midpoint of table interval idx, scaled by 2^seed_w
  function automatic longint seed_of(input int idx, input int idx_w, input int seed_w);
    longint num;
    longint den;
    num = longint'(1) << (seed_w + idx_w + 1);
    den = (longint'(1) << (idx_w + 1)) + 2 * longint'(idx) + 1;
    return (2 * num + den) / (2 * den);
  endfunction

endpackage

// File: rtl/recip_seed_rom.sv
module recip_seed_rom #(
  parameter int IDX_W  = 7,
  parameter int SEED_W = 12
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [SEED_W-1:0] seed
);
  localparam int DEPTH = 1 << IDX_W;

  logic [SEED_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    assign rom[i] = SEED_W'(recip_pkg::seed_of(i, IDX_W, SEED_W));
  end

  assign seed = rom[idx];
endmodule

// File: rtl/recip_mul.sv
module recip_mul #(
  parameter int OP_W   = 33,
  parameter int FRAC_W = 30
) (
  input  logic signed [OP_W-1:0] a,
  input  logic signed [OP_W-1:0] b,
  output logic signed [OP_W-1:0] p
);
  localparam int PW = 2 * OP_W;

  logic signed [PW-1:0] a_ext, b_ext, full;

  assign a_ext = PW'(a);
  assign b_ext = PW'(b);
  assign full  = a_ext * b_ext;
  // Rescale back to FRAC_W fractional bits (floor)
  assign p     = OP_W'(full >>> FRAC_W);
endmodule

// File: rtl/recip_pack.sv
module recip_pack
  import recip_pkg::*;
#(
  parameter int FRAC_W = 30,
  parameter int OP_W   = 33
) (
  input  op_class_t              cls,
  input  logic                   sign,
  input  logic [7:0]             exp_in,
  input  logic                   frac_zero,
  input  logic signed [OP_W-1:0] x,
  output logic [31:0]            res
);
  localparam logic signed [OP_W-1:0] X_LO =
    {{(OP_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [OP_W-1:0] X_HI =
    {{(OP_W-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};
  localparam int SUM_W = FRAC_W + 2;
  localparam logic [SUM_W-1:0] HALF = SUM_W'(1) << (FRAC_W - 25);

  logic signed [OP_W-1:0] x_cl;
  logic [SUM_W-1:0]       sum;
  logic [24:0]            sig;
  logic [22:0]            mant;
  logic                   carry;
  logic                   flush;

  always_comb begin
    if (x < X_LO)      x_cl = X_LO;
    else if (x > X_HI) x_cl = X_HI;
    else               x_cl = x;
  end

  // x_cl in [0.5,1): leading one at bit FRAC_W-1; keep 24 bits, round half up
  assign sum   = SUM_W'(x_cl) + HALF;
  assign sig   = 25'(sum >> (FRAC_W - 24));
  assign carry = sig[24];
  assign mant  = 23'(sig);
  assign flush = (exp_in == 8'd254) || ((exp_in == 8'd253) && !frac_zero);

  always_comb begin
    unique case (cls)
      CL_ZERO: res = {sign, 8'hFF, 23'd0};
      CL_INF:  res = {sign, 31'd0};
      CL_NAN:  res = 32'h7FC0_0000;
      default: begin
        if (flush)          res = {sign, 31'd0};
        else if (frac_zero) res = {sign, 8'(8'd254 - exp_in), 23'd0};
        else                res = {sign, 8'(8'd253 - exp_in) + {7'd0, carry}, mant};
      end
    endcase
  end
endmodule

// File: rtl/recip_nr_unit.sv
module recip_nr_unit
  import recip_pkg::*;
#(
  parameter int FRAC_W   = 30,
  parameter int IDX_W    = 7,
  parameter int SEED_W   = 12,
  parameter int NR_STEPS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_done,
  output logic [31:0] out_data
);
  localparam int OP_W  = FRAC_W + 3;
  localparam int CNT_W = (NR_STEPS < 2) ? 1 : $clog2(NR_STEPS);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(NR_STEPS - 1);
  localparam logic signed [OP_W-1:0] ONE =
    {{(OP_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

  recip_state_t state_q;
  op_class_t    cls_q, cls_in;
  logic         sign_q, fz_q;
  logic [7:0]   exp_q;
  logic [CNT_W-1:0] step_q;
  logic signed [OP_W-1:0] d_q, x_q, y_q;
  logic signed [OP_W-1:0] mul_a, mul_b, mul_p;
  logic [SEED_W-1:0] seed;
  logic [31:0] packed_res;
  logic [31:0] out_q;
  logic        done_q;

  recip_seed_rom #(.IDX_W(IDX_W), .SEED_W(SEED_W)) u_rom (
    .idx  (in_data[22 -: IDX_W]),
    .seed (seed)
  );

  // One multiplier: residual phase uses d*x, correction phase uses x*y
  always_comb begin
    mul_a = (state_q == ST_COR) ? x_q : d_q;
    mul_b = (state_q == ST_COR) ? y_q : x_q;
  end

  recip_mul #(.OP_W(OP_W), .FRAC_W(FRAC_W)) u_mul (
    .a (mul_a),
    .b (mul_b),
    .p (mul_p)
  );

  recip_pack #(.FRAC_W(FRAC_W), .OP_W(OP_W)) u_pack (
    .cls       (cls_q),
    .sign      (sign_q),
    .exp_in    (exp_q),
    .frac_zero (fz_q),
    .x         (x_q),
    .res       (packed_res)
  );

  always_comb begin
    if (in_data[30:23] == 8'd0)       cls_in = CL_ZERO;
    else if (in_data[30:23] != 8'hFF) cls_in = CL_NORM;
    else if (in_data[22:0] == 23'd0)  cls_in = CL_INF;
    else                              cls_in = CL_NAN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cls_q   <= CL_NORM;
      sign_q  <= 1'b0;
      fz_q    <= 1'b0;
      exp_q   <= 8'd0;
      step_q  <= '0;
      d_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      out_q   <= 32'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (in_valid) begin
            cls_q   <= cls_in;
            sign_q  <= in_data[31];
            exp_q   <= in_data[30:23];
            fz_q    <= (in_data[22:0] == 23'd0);
            d_q     <= OP_W'({1'b1, in_data[22:0], {(FRAC_W-23){1'b0}}});
            x_q     <= OP_W'({seed, {(FRAC_W-SEED_W){1'b0}}});
            step_q  <= '0;
            state_q <= ST_RES;
          end
        end
        ST_RES: begin
          y_q     <= ONE - mul_p;
          state_q <= ST_COR;
        end
        ST_COR: begin
          x_q <= x_q + mul_p;
          if (step_q == LAST_STEP) begin
            state_q <= ST_PACK;
          end else begin
            step_q  <= step_q + 1'b1;
            state_q <= ST_RES;
          end
        end
        default: begin
          out_q   <= packed_res;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign in_ready = (state_q == ST_IDLE);
  assign out_done = done_q;
  assign out_data = out_q;
endmodule

// File: rtl/recip_nr_unit_chk.sv
module recip_nr_unit_chk #(
  parameter int NR_STEPS = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_data,
  input logic        out_done,
  input logic [31:0] out_data
);
  localparam int LAT = 2 * NR_STEPS + 1;

  logic        busy;
  int          cnt;
  logic [31:0] cap;
  logic        accept;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= 0;
      cap  <= 32'd0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= 0;
      cap  <= in_data;
    end else if (out_done) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt + 1;
    end
  end

  // R1: taking an operand makes the unit busy
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R2: strobe lasts one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |=> !out_done);

  // R2: strobe comes only for a pending request, at the fixed latency
  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (busy && cnt == LAT));

  // R2: result register only moves together with the strobe
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(out_data) |-> out_done);

  // R5: zero or denormal gives signed infinity
  a_r5_zero_to_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && cap[30:23] == 8'd0) |-> (out_data == {cap[31], 8'hFF, 23'd0}));

  // R6: infinity gives signed zero
  a_r6_inf_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && cap[30:23] == 8'hFF && cap[22:0] == 23'd0) |-> (out_data == {cap[31], 31'd0}));

  // R7: NaN gives the quiet NaN
  a_r7_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && cap[30:23] == 8'hFF && cap[22:0] != 23'd0) |-> (out_data == 32'h7FC0_0000));
endmodule

bind recip_nr_unit recip_nr_unit_chk #(.NR_STEPS(NR_STEPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .out_done (out_done),
  .out_data (out_data)
);

// File: tb/recip_nr_unit_tb.sv
`timescale 1ns/1ps
module recip_nr_unit_tb;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = 32'd0;
  logic        out_done;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #2.5 clk = ~clk;

  recip_nr_unit u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .out_done (out_done),
    .out_data (out_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp_v);
    end
  endtask

  function automatic real pow2(input int k);
    real v = 1.0;
    if (k >= 0) for (int i = 0; i < k; i++) v = v * 2.0;
    else for (int i = 0; i < -k; i++) v = v / 2.0;
    return v;
  endfunction

  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
  endtask

  task automatic check_result(input logic [31:0] a, input logic [31:0] res);
    logic       s;
    logic [7:0] e;
    logic [22:0] f;
    int oe;
    real x, r, v, ulp, diff;
    s = a[31]; e = a[30:23]; f = a[22:0];
    if (e == 8'd0)
      check(res == {s, 8'hFF, 23'd0}, "R5", res, {s, 8'hFF, 23'd0});
    else if (e == 8'hFF && f == 23'd0)
      check(res == {s, 31'd0}, "R6", res, {s, 31'd0});
    else if (e == 8'hFF)
      check(res == 32'h7FC0_0000, "R7", res, 32'h7FC0_0000);
    else if (e == 8'd254 || (e == 8'd253 && f != 23'd0))
      check(res == {s, 31'd0}, "R8", res, {s, 31'd0});
    else if (f == 23'd0)
      check(res == {s, 8'(8'd254 - e), 23'd0}, "R4", res, {s, 8'(8'd254 - e), 23'd0});
    else begin
      x = (1.0 + real'(f) / 8388608.0) * pow2(int'(e) - 127);
      r = 1.0 / x;
      oe = int'(res[30:23]);
      if (res[31] != s || oe == 0 || oe == 255) begin
        check(1'b0, "R3", res, 32'h0);
      end else begin
        v = (1.0 + real'(res[22:0]) / 8388608.0) * pow2(oe - 127);
        ulp = pow2(oe - 150);
        diff = (v > r) ? v - r : r - v;
        check(diff <= ulp, "R3", res, {s, 31'd0});
      end
    end
  endtask

  task automatic run_op(input logic [31:0] a, input bit noisy);
    logic [31:0] res;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready when idle", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1;
    in_data  = a;
    for (int k = 0; k < LAT; k++) begin
      @(negedge clk);
      if (k == 0) begin
        if (noisy) in_data = ~a ^ 32'h0F0F_1234;
        else in_valid = 1'b0;
      end
      check(out_done == 1'b0, "R2 no early done", {31'd0, out_done}, 32'd0);
      check(in_ready == 1'b0, "R1 busy", {31'd0, in_ready}, 32'd0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_done == 1'b1, "R2 done at latency", {31'd0, out_done}, 32'd1);
    res = out_data;
    check_result(a, res);
    @(negedge clk);
    check(out_done == 1'b0, "R2 single cycle", {31'd0, out_done}, 32'd0);
    check(out_data == res, "R2 hold", out_data, res);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] low;
    logic [7:0]  e;
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R9 ready", {31'd0, in_ready}, 32'd1);
    check(out_done == 1'b0, "R9 done", {31'd0, out_done}, 32'd0);
    check(out_data == 32'd0, "R9 data", out_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && out_data == 32'd0, "R9 after release", out_data, 32'd0);

    // specials and boundaries
    run_op(32'h0000_0000, 1'b0);  // R5
    run_op(32'h8000_0000, 1'b1);  // R5
    run_op(32'h0000_0001, 1'b0);  // R5 denormal
    run_op(32'h807F_FFFF, 1'b0);  // R5 denormal
    run_op(32'h7F80_0000, 1'b0);  // R6
    run_op(32'hFF80_0000, 1'b1);  // R6
    run_op(32'h7FC0_0001, 1'b0);  // R7
    run_op(32'hFF80_0001, 1'b0);  // R7
    run_op(32'h7F00_0000, 1'b0);  // R8 e=254
    run_op(32'hFEA0_0000, 1'b0);  // R8 e=253
    run_op(32'h7E80_0000, 1'b0);  // R4 e=253 -> smallest normal
    run_op(32'h0080_0000, 1'b0);  // R4 e=1
    run_op(32'h3F80_0000, 1'b0);  // R4 one
    run_op(32'h3F80_0001, 1'b1);  // R3 just above one
    run_op(32'h3FFF_FFFF, 1'b0);  // R3 just below two
    run_op(32'h4040_0000, 1'b0);  // R3 three

    // sweep every table interval with several low patterns
    for (int i = 0; i < 128; i++) begin
      for (int j = 0; j < 4; j++) begin
        step_lfsr();
        case (j)
          0: low = 16'h0000;
          1: low = 16'h0001;
          2: low = 16'hFFFF;
          default: low = lfsr[15:0];
        endcase
        e = 8'(1 + ((i * 5 + j * 61) % 252));
        run_op({1'(i ^ j), e, 7'(i), low}, ((i + j) % 7) == 0);
      end
    end

    // pseudo-random operands across all classes
    for (int n = 0; n < 1200; n++) begin
      step_lfsr();
      run_op(lfsr, (n % 9) == 0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule